// File: doc/BRIEF.md
# CAN Controller Interrupt Flag and Enable Unit

This block gathers eight event sources from a CAN controller core into a sticky interrupt flag register. It pairs that register with an enable mask and drives one combined interrupt request. Seven sources are single-cycle event pulses from the protocol engine. The receive-valid source is fed from a level that says unread frames are waiting, so this flag keeps coming back for as long as frames remain.

Software uses a small synchronous register port with an address, a write strobe, write data and read data. Through it, software reads the flags, clears them by writing ones, and reads or writes the enable mask. A write-only command address decodes two one-shot strobes for the core: one releases the receive buffer, the other clears the overrun condition. The protocol engine, the bit timing and the message storage sit outside this block.

Top module: `can_irq_unit`

## Requirements
- R1: After reset the flag register and the enable register both read 0x00, irq_o is low and both command strobes are low.
- R2: An event pulse sets its flag on the next clock edge whether or not that source is enabled. The flag bit positions are: 7 bus error, 6 arbitration lost, 5 error passive, 4 wakeup, 3 data overrun, 2 error warning, 1 transmit complete, 0 receive valid.
- R3: A write to address 0 clears every flag whose write-data bit is 1 and leaves flags under 0 bits unchanged, so writing back a value that was read clears exactly those flags.
- R4: When a source event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R5: The receive-valid flag (bit 0) is also set on every edge where rx_pend_i is high, so after a clear it returns on the next cycle while rx_pend_i stays high.
- R6: Address 1 holds the enable register, with the same bit layout as the flags, and it reads back the last value written. Writing 0x7F masks the bus error source only.
- R7: irq_o is high exactly when some flag and its enable bit are both 1 in the registered state.
- R8: A write to address 2 with bit 2 set makes rel_rxbuf_o high for the single cycle after the write. Bit 3 does the same for clr_ovr_o. With no such write, both stay low.
- R9: Reads of address 2 (command) and address 3 (unused) return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ev_i | input | 8 | Single-cycle event pulses, one per flag bit |
| rx_pend_i | input | 1 | Level: unread received frames remain |
| addr_i | input | 2 | Register address: 0 flags, 1 enable, 2 command, 3 unused |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Combined interrupt request |
| rel_rxbuf_o | output | 1 | One-cycle release-receive-buffer strobe |
| clr_ovr_o | output | 1 | One-cycle clear-overrun strobe |

## Verification
The two functions that can land in the same cycle are a source setting a flag and a software write-one-to-clear of that flag. The level-fed receive flag adds a second case, because it can be cleared while its level input is still high. The bench provokes both with directed cycles that pulse an event, or hold rx_pend_i high, in the same cycle as a clearing write to the same bit, and then reads the flag back to confirm it stayed set. Random traffic also makes such overlaps often, and each one is judged against a bench model in which the set dominates the clear.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int unsigned NSRC = 8;
  localparam int unsigned AW   = 2;

  typedef enum logic [AW-1:0] {
    A_FLAG = 2'd0,
    A_EN   = 2'd1,
    A_CMD  = 2'd2,
    A_RSV  = 2'd3
  } reg_addr_e;

  // flag / enable bit map
  localparam int unsigned B_RX    = 0;
  localparam int unsigned B_TX    = 1;
  localparam int unsigned B_EWARN = 2;
  localparam int unsigned B_OVR   = 3;
  localparam int unsigned B_WAKE  = 4;
  localparam int unsigned B_EPASS = 5;
  localparam int unsigned B_ARB   = 6;
  localparam int unsigned B_BERR  = 7;

  // command bits
  localparam int unsigned C_REL    = 2;
  localparam int unsigned C_CLROVR = 3;
endpackage

// File: rtl/irq_flag_bit.sv
module irq_flag_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else         q <= set_i | (q & ~clr_i);
  end

  assign q_o = q;
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= d_i;
  end

  assign q_o = q;
endmodule

// File: rtl/irq_cmd_pulse.sv
module irq_cmd_pulse #(
  parameter int unsigned W   = 8,
  parameter int unsigned BIT = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fire_i,
  input  logic [W-1:0] wdata_i,
  output logic         pulse_o
);
  logic p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) p <= 1'b0;
    else         p <= fire_i & wdata_i[BIT];
  end

  assign pulse_o = p;
endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
  import can_irq_pkg::*;
#(
  parameter int unsigned DW = NSRC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] ev_i,
  input  logic          rx_pend_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          rel_rxbuf_o,
  output logic          clr_ovr_o
);
  localparam int unsigned NF = NSRC;

  logic [NF-1:0] flag_q;
  logic [NF-1:0] en_q;
  logic [NF-1:0] set_v;
  logic [NF-1:0] clr_v;
  logic          wr_flag, wr_en, wr_cmd;

  assign wr_flag = we_i & (addr_i == A_FLAG);
  assign wr_en   = we_i & (addr_i == A_EN);
  assign wr_cmd  = we_i & (addr_i == A_CMD);

  generate
    for (genvar i = 0; i < NF; i++) begin : g_flag
      if (i == B_RX) begin : g_lvl
        assign set_v[i] = ev_i[i] | rx_pend_i;
      end else begin : g_evt
        assign set_v[i] = ev_i[i];
      end
      assign clr_v[i] = wr_flag & wdata_i[i];

      irq_flag_bit u_bit (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (set_v[i]),
        .clr_i  (clr_v[i]),
        .q_o    (flag_q[i])
      );
    end
  endgenerate

  irq_en_reg #(.W(NF)) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en),
    .d_i    (wdata_i[NF-1:0]),
    .q_o    (en_q)
  );

  irq_cmd_pulse #(.W(DW), .BIT(C_REL)) u_rel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (wr_cmd),
    .wdata_i (wdata_i),
    .pulse_o (rel_rxbuf_o)
  );

  irq_cmd_pulse #(.W(DW), .BIT(C_CLROVR)) u_clrovr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (wr_cmd),
    .wdata_i (wdata_i),
    .pulse_o (clr_ovr_o)
  );

  assign irq_o = |(flag_q & en_q);

  always_comb begin
    rdata_o = '0;
    case (reg_addr_e'(addr_i))
      A_FLAG:  rdata_o[NF-1:0] = flag_q;
      A_EN:    rdata_o[NF-1:0] = en_q;
      default: rdata_o = '0; // command is write-only
    endcase
  end
endmodule

// File: rtl/can_irq_unit_chk.sv
module can_irq_unit_chk
  import can_irq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] ev_i,
  input logic       rx_pend_i,
  input logic [1:0] addr_i,
  input logic       we_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       irq_o,
  input logic       rel_rxbuf_o,
  input logic       clr_ovr_o,
  input logic [7:0] flag_q,
  input logic [7:0] en_q
);
  // R2 R4
  ev_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i != 8'h00) |=> ((flag_q & $past(ev_i)) == $past(ev_i)));

  // R3
  w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_FLAG) |=>
      ((flag_q & $past(wdata_i & ~ev_i & ~{7'b0, rx_pend_i})) == 8'h00));

  // R5
  rx_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pend_i |=> flag_q[B_RX]);

  // R7
  irq_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & en_q) == 8'h00) |-> !irq_o);

  // R7
  irq_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & en_q) != 8'h00) |-> irq_o);

  // R8
  rel_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_rxbuf_o |-> $past(we_i && addr_i == A_CMD && wdata_i[C_REL]));

  // R8
  clrovr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ovr_o |-> $past(we_i && addr_i == A_CMD && wdata_i[C_CLROVR]));

  // R9
  cmd_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CMD || addr_i == A_RSV) |-> (rdata_o == 8'h00));

  // R6
  en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_EN) |=> (en_q == $past(wdata_i)));
endmodule

bind can_irq_unit can_irq_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ev_i        (ev_i),
  .rx_pend_i   (rx_pend_i),
  .addr_i      (addr_i),
  .we_i        (we_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .irq_o       (irq_o),
  .rel_rxbuf_o (rel_rxbuf_o),
  .clr_ovr_o   (clr_ovr_o),
  .flag_q      (flag_q),
  .en_q        (en_q)
);

// File: tb/tb_can_irq_unit.sv
module tb_can_irq_unit;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] ev_i = '0;
  logic       rx_pend_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o, rel_rxbuf_o, clr_ovr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] m_flag = '0;
  logic [7:0] m_en   = '0;
  logic       m_rel  = 1'b0;
  logic       m_co   = 1'b0;

  can_irq_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ev_i(ev_i), .rx_pend_i(rx_pend_i),
    .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .rel_rxbuf_o(rel_rxbuf_o), .clr_ovr_o(clr_ovr_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_flag;
      2'd1:    return m_en;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string read_req(input logic [1:0] a);
    if (a == 2'd0) return "R2";
    if (a == 2'd1) return "R6";
    return "R9";
  endfunction

  // one bus cycle: check outputs of the previous edge, drive, check read, advance model
  task automatic step(input logic [7:0] ev, input logic rxp, input logic [1:0] a,
                      input logic w, input logic [7:0] d, output logic [7:0] rd);
    logic [7:0] clr;
    @(negedge clk_i);
    chk(irq_o == |(m_flag & m_en), "R7", {7'b0, irq_o}, {7'b0, |(m_flag & m_en)});
    chk(rel_rxbuf_o == m_rel, "R8", {7'b0, rel_rxbuf_o}, {7'b0, m_rel});
    chk(clr_ovr_o == m_co, "R8", {7'b0, clr_ovr_o}, {7'b0, m_co});
    ev_i = ev; rx_pend_i = rxp; addr_i = a; we_i = w; wdata_i = d;
    #1;
    rd = rdata_o;
    if (!w) chk(rdata_o == exp_read(a), read_req(a), rdata_o, exp_read(a));
    @(posedge clk_i);
    clr    = (w && a == 2'd0) ? d : 8'h00;
    m_flag = (ev | {7'b0, rxp}) | (m_flag & ~clr);
    if (w && a == 2'd1) m_en = d;
    m_rel  = w && a == 2'd2 && d[2];
    m_co   = w && a == 2'd2 && d[3];
  endtask

  task automatic idle_read(input logic [1:0] a, output logic [7:0] rd);
    step(8'h00, 1'b0, a, 1'b0, 8'h00, rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0x%02h expected 0x%02h", 8'h00, 8'h01);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h5EED_1234));

    // R1 reset state
    #(CLK_PERIOD * 2);
    addr_i = 2'd0; #1;
    chk(rdata_o == 8'h00, "R1", rdata_o, 8'h00);
    addr_i = 2'd1; #1;
    chk(rdata_o == 8'h00, "R1", rdata_o, 8'h00);
    chk(irq_o == 1'b0 && rel_rxbuf_o == 1'b0 && clr_ovr_o == 1'b0, "R1",
        {5'b0, irq_o, rel_rxbuf_o, clr_ovr_o}, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;

    // R2 event sets flag while disabled, no irq
    step(8'h80, 1'b0, 2'd0, 1'b0, 8'h00, rd);
    idle_read(2'd0, rd);
    chk(rd == 8'h80, "R2", rd, 8'h80);
    chk(irq_o == 1'b0, "R2", {7'b0, irq_o}, 8'h00);

    // R6 mask only bus error
    step(8'h00, 1'b0, 2'd1, 1'b1, 8'h7F, rd);
    idle_read(2'd1, rd);
    chk(rd == 8'h7F, "R6", rd, 8'h7F);
    chk(irq_o == 1'b0, "R6", {7'b0, irq_o}, 8'h00);
    step(8'h02, 1'b0, 2'd0, 1'b0, 8'h00, rd);
    idle_read(2'd0, rd);
    chk(irq_o == 1'b1, "R7", {7'b0, irq_o}, 8'h01);

    // R3 write back read value clears exactly those flags
    idle_read(2'd0, rd);
    step(8'h00, 1'b0, 2'd0, 1'b1, rd, rd);
    idle_read(2'd0, rd);
    chk(rd == 8'h00, "R3", rd, 8'h00);
    step(8'h28, 1'b0, 2'd0, 1'b0, 8'h00, rd);
    step(8'h00, 1'b0, 2'd0, 1'b1, 8'h08, rd);
    idle_read(2'd0, rd);
    chk(rd == 8'h20, "R3", rd, 8'h20);

    // R4 set and clear same cycle
    step(8'h10, 1'b0, 2'd0, 1'b1, 8'hFF, rd);
    idle_read(2'd0, rd);
    chk(rd == 8'h10, "R4", rd, 8'h10);

    // R5 rx level re-asserts after clear
    step(8'h00, 1'b1, 2'd0, 1'b1, 8'hFF, rd);
    step(8'h00, 1'b1, 2'd0, 1'b1, 8'h01, rd);
    step(8'h00, 1'b1, 2'd0, 1'b0, 8'h00, rd);
    chk(rd[0] == 1'b1, "R5", rd, 8'h01);
    step(8'h00, 1'b0, 2'd0, 1'b1, 8'h01, rd);
    idle_read(2'd0, rd);
    chk(rd[0] == 1'b0, "R5", rd, 8'h00);

    // R8 command strobes, R9 command read
    step(8'h00, 1'b0, 2'd2, 1'b1, 8'h0C, rd);
    @(negedge clk_i);
    chk(rel_rxbuf_o && clr_ovr_o, "R8", {6'b0, rel_rxbuf_o, clr_ovr_o}, 8'h03);
    idle_read(2'd2, rd);
    chk(rd == 8'h00, "R9", rd, 8'h00);
    idle_read(2'd3, rd);
    chk(rd == 8'h00, "R9", rd, 8'h00);
    step(8'h00, 1'b0, 2'd2, 1'b1, 8'h04, rd);
    idle_read(2'd0, rd);
    chk(rel_rxbuf_o == 1'b1 && clr_ovr_o == 1'b0, "R8", {6'b0, rel_rxbuf_o, clr_ovr_o}, 8'h02);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] ev;
      logic [7:0] d;
      ev = 8'($urandom) & 8'($urandom) & 8'($urandom);
      d  = 8'($urandom);
      step(ev, ($urandom % 4) == 0, 2'($urandom), ($urandom % 3) == 0, d, rd);
    end
    idle_read(2'd0, rd);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule